// File: doc/BRIEF.md
# PLL Operating Mode Controller

This block supervises the operating mode of a digital phase-locked loop. When the chip's initialization sequence finishes, it places the loop in free-run without any command. It starts lock acquisition as soon as any reference input is flagged valid. It declares lock only after the lock detector has stayed asserted for a programmable number of consecutive cycles while the selected reference is valid. When every reference disappears while locked, it falls into a holdover state.

The controller drives three things. The first is a 2-bit mode code. The second is the loop bandwidth select: fast bandwidth is used only during acquisition and only when fast lock is enabled, and it reverts to normal bandwidth at the same edge that lock is declared. The third is a loss-of-lock indication, given both as a pin and as a matching status bit. The phase detector, loop filter, oscillator and input validity monitors are outside the block and are seen only through its inputs.

Top module: `pll_mode_ctrl`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, the mode is free-run, loss-of-lock is high and the bandwidth select is normal (0).
- R2: While `init_done` is low, the mode is free-run one cycle later, whatever the state and inputs were; valid inputs cannot start acquisition before initialization completes.
- R3: In free-run with `init_done` high, the mode becomes acquisition one cycle after any bit of `in_valid` is 1.
- R4: In acquisition, the mode becomes locked at the edge that completes `qual_len` consecutive cycles in which `lock_det` is 1 and the selected input is valid. A cycle without this restarts the count, and a `qual_len` of 0 acts as 1.
- R5: `lock_det` is not counted in a cycle where `in_valid[sel_idx]` is 0, even if other inputs are valid.
- R6: In locked mode with at least one input valid, a cycle with `lock_det` low or the selected input invalid returns the mode to acquisition, with loss-of-lock high, one cycle later.
- R7: In locked mode with no input valid, the mode becomes holdover one cycle later; this takes priority over R6. In acquisition with no input valid, the mode returns to free-run.
- R8: In holdover, the mode becomes acquisition one cycle after any input becomes valid. It becomes free-run one cycle after `init_done` drops, and it stays in holdover otherwise.
- R9: The bandwidth select is 1 (fast) exactly when the mode is acquisition and `fastlock_en` was 1 at the edge that produced that cycle's mode. With `fastlock_en` low, it stays 0 in every mode.
- R10: `lol_pin` and `lol_bit` are always equal, and they are 1 exactly when the mode is not locked.
- R11: The mode code is 2'b00 free-run, 2'b01 acquisition, 2'b10 locked, 2'b11 holdover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_done | input | 1 | Initialization sequence complete |
| in_valid | input | N_IN | Per-input reference clock valid flags |
| sel_idx | input | $clog2(N_IN) | Index of the reference the loop tracks |
| lock_det | input | 1 | Lock detector indication |
| fastlock_en | input | 1 | Use fast bandwidth during acquisition |
| qual_len | input | CNT_W | Consecutive lock cycles required before lock is declared |
| mode_o | output | 2 | Current mode code (R11) |
| bw_fast_o | output | 1 | 1 = fast-lock bandwidth, 0 = normal bandwidth |
| lol_pin_o | output | 1 | Loss-of-lock pin, 1 = not locked |
| lol_bit_o | output | 1 | Loss-of-lock status bit, mirrors the pin |

## Verification
Every output comes from a register, so a change on `init_done`, `in_valid`, `lock_det` or `fastlock_en` shows up on the outputs exactly one rising edge later. Lock declaration is the exception: it appears `qual_len` edges after `lock_det` rises, or immediately after the last counted cycle. The bench changes inputs only on falling edges and reads outputs on the next falling edge, so each check sits half a period after the edge that must have produced the result. For the qualification window, the bench checks the mode after each counted edge, confirming it is still acquisition up to the last edge and locked right after it.

// File: rtl/pll_mode_pkg.sv
// Package: mode encoding shared by the controller, its submodules and checker.
// Assumes the 2-bit codes are decoded outside the block, so their values are fixed.
package pll_mode_pkg;

    typedef enum logic [1:0] {
        MODE_FREE = 2'b00,
        MODE_ACQ  = 2'b01,
        MODE_LOCK = 2'b10,
        MODE_HOLD = 2'b11
    } pll_mode_e;

endpackage

// File: rtl/pll_ref_select.sv
// Reference validity reduction: reports whether any input is valid and whether
// the selected input is valid. Assumes in_valid is already synchronous to clk.
// An index beyond N_IN-1 counts as an invalid selection.
module pll_ref_select #(
    parameter int N_IN  = 4,
    parameter int SEL_W = 2
) (
    input  logic [N_IN-1:0]  in_valid,
    input  logic [SEL_W-1:0] sel_idx,
    output logic             any_valid,
    output logic             sel_valid
);

    logic [N_IN-1:0] match_vec;

    // One match term per input: that input is valid and it is the selected one.
    for (genvar g = 0; g < N_IN; g++) begin : g_match
        assign match_vec[g] = in_valid[g] && (sel_idx == SEL_W'(g));
    end

    // Reduce the per-input terms to the two flags.
    always_comb begin
        any_valid = |in_valid;
        sel_valid = |match_vec;
    end

endmodule

// File: rtl/pll_lock_qual.sv
// Lock qualification counter: counts consecutive good cycles while enabled and
// flags the cycle that completes the programmed run. A qual_len of 0 is taken
// as 1. The count restarts on any cycle that is not good or not enabled.
module pll_lock_qual #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             good,
    input  logic [CNT_W-1:0] qual_len,
    output logic             done
);

    localparam int EXT_W = CNT_W + 1;

    logic [CNT_W-1:0] run_cnt;
    logic [EXT_W-1:0] target;
    logic [EXT_W-1:0] run_next;

    // Effective target length and the count this cycle would reach.
    always_comb begin
        target   = (qual_len == '0) ? EXT_W'(1) : {1'b0, qual_len};
        run_next = {1'b0, run_cnt} + EXT_W'(1);
        done     = enable && good && (run_next >= target);
    end

    // Consecutive-cycle counter, cleared on a break or on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (!enable || !good || done) begin
            run_cnt <= '0;
        end else begin
            run_cnt <= run_next[CNT_W-1:0];
        end
    end

endmodule

// File: rtl/pll_mode_fsm.sv
// Mode state machine: holds the current mode and computes the next one from
// init status, reference validity and qualified lock. Assumes qual_done is
// only raised while the state is acquisition.
module pll_mode_fsm
    import pll_mode_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      init_done,
    input  logic      any_valid,
    input  logic      sel_valid,
    input  logic      lock_det,
    input  logic      qual_done,
    output pll_mode_e mode_q,
    output pll_mode_e mode_d
);

    // Next-mode selection; loss of initialization overrides everything.
    always_comb begin
        mode_d = mode_q;
        if (!init_done) begin
            mode_d = MODE_FREE;
        end else begin
            unique case (mode_q)
                MODE_FREE: if (any_valid) mode_d = MODE_ACQ;
                MODE_ACQ: begin
                    if (!any_valid)     mode_d = MODE_FREE;
                    else if (qual_done) mode_d = MODE_LOCK;
                end
                MODE_LOCK: begin
                    if (!any_valid)                  mode_d = MODE_HOLD;
                    else if (!lock_det || !sel_valid) mode_d = MODE_ACQ;
                end
                MODE_HOLD: if (any_valid) mode_d = MODE_ACQ;
                default: mode_d = MODE_FREE;
            endcase
        end
    end

    // Mode register.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_FREE;
        else        mode_q <= mode_d;
    end

endmodule

// File: rtl/pll_mode_outs.sv
// Output stage: registers the bandwidth select and both loss-of-lock flags from
// the next mode, so they change on the same edge as the mode register.
module pll_mode_outs
    import pll_mode_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  pll_mode_e mode_d,
    input  logic      fastlock_en,
    output logic      bw_fast_q,
    output logic      lol_pin_q,
    output logic      lol_bit_q
);

    // Registered status derived from the upcoming mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bw_fast_q <= 1'b0;
            lol_pin_q <= 1'b1;
            lol_bit_q <= 1'b1;
        end else begin
            bw_fast_q <= fastlock_en && (mode_d == MODE_ACQ);
            lol_pin_q <= (mode_d != MODE_LOCK);
            lol_bit_q <= (mode_d != MODE_LOCK);
        end
    end

endmodule

// File: rtl/pll_mode_ctrl.sv
// Top of the PLL mode controller: ties together reference selection, lock
// qualification, the mode state machine and the output register stage.
// Assumes every input is synchronous to clk.
module pll_mode_ctrl
    import pll_mode_pkg::*;
#(
    parameter int N_IN  = 4,
    parameter int CNT_W = 8,
    localparam int SEL_W = (N_IN > 1) ? $clog2(N_IN) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_done,
    input  logic [N_IN-1:0]  in_valid,
    input  logic [SEL_W-1:0] sel_idx,
    input  logic             lock_det,
    input  logic             fastlock_en,
    input  logic [CNT_W-1:0] qual_len,
    output logic [1:0]       mode_o,
    output logic             bw_fast_o,
    output logic             lol_pin_o,
    output logic             lol_bit_o
);

    logic      any_valid;
    logic      sel_valid;
    logic      qual_done;
    logic      qual_en;
    pll_mode_e mode_q;
    pll_mode_e mode_d;

    pll_ref_select #(.N_IN(N_IN), .SEL_W(SEL_W)) i_ref_select (
        .in_valid  (in_valid),
        .sel_idx   (sel_idx),
        .any_valid (any_valid),
        .sel_valid (sel_valid)
    );

    // Qualification runs only during acquisition with initialization complete.
    always_comb qual_en = (mode_q == MODE_ACQ) && init_done && any_valid;

    pll_lock_qual #(.CNT_W(CNT_W)) i_lock_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (qual_en),
        .good     (lock_det && sel_valid),
        .qual_len (qual_len),
        .done     (qual_done)
    );

    pll_mode_fsm i_mode_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .init_done (init_done),
        .any_valid (any_valid),
        .sel_valid (sel_valid),
        .lock_det  (lock_det),
        .qual_done (qual_done),
        .mode_q    (mode_q),
        .mode_d    (mode_d)
    );

    pll_mode_outs i_mode_outs (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_d      (mode_d),
        .fastlock_en (fastlock_en),
        .bw_fast_q   (bw_fast_o),
        .lol_pin_q   (lol_pin_o),
        .lol_bit_q   (lol_bit_o)
    );

    // Mode code on the port.
    always_comb mode_o = mode_q;

endmodule

// File: rtl/pll_mode_ctrl_chk.sv
// Checker for the PLL mode controller, attached to every instance by bind.
// Observes only the top-level ports.
module pll_mode_ctrl_chk #(
    parameter int N_IN = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            init_done,
    input logic [N_IN-1:0] in_valid,
    input logic            lock_det,
    input logic            fastlock_en,
    input logic [1:0]      mode_o,
    input logic            bw_fast_o,
    input logic            lol_pin_o,
    input logic            lol_bit_o
);

    AST_INIT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |=> mode_o == 2'b00); // R2

    AST_FREE_TO_ACQ: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b00 && init_done && |in_valid) |=> mode_o == 2'b01); // R3

    AST_NO_LOCK_WITHOUT_DET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b01 && !lock_det) |=> mode_o != 2'b10); // R4

    AST_LOCK_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b10 && init_done && |in_valid && !lock_det)
        |=> (mode_o == 2'b01 && lol_pin_o)); // R6

    AST_TO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b10 && init_done && in_valid == '0) |=> mode_o == 2'b11); // R7

    AST_HOLD_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b11 && init_done && |in_valid) |=> mode_o == 2'b01); // R8

    AST_BW_ONLY_ACQ: assert property (@(posedge clk) disable iff (!rst_n)
        bw_fast_o |-> mode_o == 2'b01); // R9

    AST_BW_FOLLOWS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b01) |-> bw_fast_o == $past(fastlock_en)); // R9

    AST_LOL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (lol_pin_o == lol_bit_o) && (lol_pin_o == (mode_o != 2'b10))); // R10

endmodule

bind pll_mode_ctrl pll_mode_ctrl_chk #(.N_IN(N_IN)) i_pll_mode_ctrl_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .init_done   (init_done),
    .in_valid    (in_valid),
    .lock_det    (lock_det),
    .fastlock_en (fastlock_en),
    .mode_o      (mode_o),
    .bw_fast_o   (bw_fast_o),
    .lol_pin_o   (lol_pin_o),
    .lol_bit_o   (lol_bit_o)
);

// File: tb/test_pll_mode_ctrl.sv
`timescale 1ns/1ps
// Directed bench for the PLL mode controller: one task per scenario.
module test_pll_mode_ctrl;

    localparam int N_IN  = 4;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             init_done = 1'b0;
    logic [N_IN-1:0]  in_valid = '0;
    logic [1:0]       sel_idx = '0;
    logic             lock_det = 1'b0;
    logic             fastlock_en = 1'b0;
    logic [CNT_W-1:0] qual_len = 8'd1;
    logic [1:0]       mode_o;
    logic             bw_fast_o;
    logic             lol_pin_o;
    logic             lol_bit_o;

    int checks = 0;
    int errors = 0;

    localparam logic [1:0] M_FREE = 2'b00, M_ACQ = 2'b01, M_LOCK = 2'b10, M_HOLD = 2'b11;

    always #2.5 clk = ~clk;

    pll_mode_ctrl #(.N_IN(N_IN), .CNT_W(CNT_W)) i_pll_mode_ctrl (
        .clk (clk), .rst_n (rst_n), .init_done (init_done), .in_valid (in_valid),
        .sel_idx (sel_idx), .lock_det (lock_det), .fastlock_en (fastlock_en),
        .qual_len (qual_len), .mode_o (mode_o), .bw_fast_o (bw_fast_o),
        .lol_pin_o (lol_pin_o), .lol_bit_o (lol_bit_o)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    // Mode plus the loss-of-lock pair, which must track it (R10).
    task automatic chk_mode(input logic [1:0] exp, input string what);
        chk(mode_o, exp, what);
        chk(lol_pin_o, exp != M_LOCK, {what, " R10 lol_pin"});
        chk(lol_bit_o, exp != M_LOCK, {what, " R10 lol_bit"});
    endtask

    // Drive into locked mode on input 1 with a one-cycle qualification.
    task automatic go_lock();
        init_done = 1'b1; in_valid = 4'b0010; sel_idx = 2'd1;
        lock_det = 1'b1; qual_len = 8'd1;
        step(2);
        chk_mode(M_LOCK, "helper lock");
    endtask

    task automatic t_reset();
        step(2);
        chk_mode(M_FREE, "R1 in reset");
        chk(bw_fast_o, 0, "R1 bw in reset");
        rst_n = 1'b1;
        step(1);
        chk_mode(M_FREE, "R1 after reset");
        chk(bw_fast_o, 0, "R1 bw after reset");
    endtask

    task automatic t_init_gate();
        in_valid = 4'b0010; sel_idx = 2'd1; fastlock_en = 1'b1;
        step(3);
        chk_mode(M_FREE, "R2 no acq before init");
        init_done = 1'b1;
        step(1);
        chk_mode(M_ACQ, "R3 free to acq");
        chk(bw_fast_o, 1, "R9 fast bw in acq");
    endtask

    task automatic t_qual();
        qual_len = 8'd4;
        lock_det = 1'b1;
        for (int i = 0; i < 3; i++) begin
            step(1);
            chk_mode(M_ACQ, "R4 before window ends");
        end
        lock_det = 1'b0;
        step(1);
        chk_mode(M_ACQ, "R4 gap");
        lock_det = 1'b1;
        for (int i = 0; i < 3; i++) begin
            step(1);
            chk_mode(M_ACQ, "R4 count restarted");
        end
        step(1);
        chk_mode(M_LOCK, "R4 locked after window");
        chk(bw_fast_o, 0, "R9 normal bw when locked");
    endtask

    task automatic t_lock_drop();
        lock_det = 1'b0;
        step(1);
        chk_mode(M_ACQ, "R6 lock drop");
        chk(bw_fast_o, 1, "R9 fast bw back in acq");
    endtask

    task automatic t_sel_invalid();
        qual_len = 8'd4; sel_idx = 2'd2; in_valid = 4'b0010; lock_det = 1'b1;
        step(6);
        chk_mode(M_ACQ, "R5 unselected valid not counted");
        sel_idx = 2'd1;
        step(3);
        chk_mode(M_ACQ, "R5 counting selected");
        step(1);
        chk_mode(M_LOCK, "R5 locked on selected");
        sel_idx = 2'd0;
        step(1);
        chk_mode(M_ACQ, "R6 selected input lost");
    endtask

    task automatic t_holdover();
        go_lock();
        in_valid = '0; lock_det = 1'b0;
        step(1);
        chk_mode(M_HOLD, "R7 enter holdover");
        step(2);
        chk_mode(M_HOLD, "R8 stay holdover");
        chk(bw_fast_o, 0, "R9 normal bw in holdover");
        in_valid = 4'b0100;
        step(1);
        chk_mode(M_ACQ, "R8 holdover to acq");
        in_valid = '0;
        step(1);
        chk_mode(M_FREE, "R7 acq without input");
        go_lock();
        in_valid = '0;
        step(1);
        chk_mode(M_HOLD, "R7 holdover again");
        init_done = 1'b0;
        step(1);
        chk_mode(M_FREE, "R8 holdover to free");
        in_valid = 4'b1111;
        step(2);
        chk_mode(M_FREE, "R2 init low holds free");
    endtask

    task automatic t_qual_zero();
        init_done = 1'b1; in_valid = 4'b0001; sel_idx = 2'd0;
        lock_det = 1'b0; qual_len = 8'd0;
        step(1);
        chk_mode(M_ACQ, "R3 acq for zero length");
        lock_det = 1'b1;
        step(1);
        chk_mode(M_LOCK, "R4 zero length acts as one");
        init_done = 1'b0;
        step(1);
        chk_mode(M_FREE, "R2 init drop from lock");
    endtask

    task automatic t_fast_off();
        fastlock_en = 1'b0; lock_det = 1'b0; in_valid = 4'b0001;
        init_done = 1'b1;
        step(1);
        chk_mode(M_ACQ, "R11 acq code");
        chk(bw_fast_o, 0, "R9 normal bw with fast lock off");
        fastlock_en = 1'b1;
        step(1);
        chk(bw_fast_o, 1, "R9 fast bw follows enable");
        fastlock_en = 1'b0;
        step(1);
        chk(bw_fast_o, 0, "R9 fast bw drops with enable");
    endtask

    initial begin
        t_reset();
        t_init_gate();
        t_qual();
        t_lock_drop();
        t_sel_invalid();
        t_holdover();
        t_qual_zero();
        t_fast_off();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule